// File: doc/BRIEF.md
# Two-Way Significand Alignment Shifter

This block right-aligns the significand of the smaller floating-point operand ahead of the significand adder. It takes a 53-bit significand (hidden bit included) and a shift distance. It returns the shifted significand together with a guard bit, a round bit and a sticky bit. The sticky bit collects every bit that falls below the round position.

The shifter has two routes. A shift distance of 0 to 3 is finished by the first shift stage and goes straight to the output register, so it arrives one cycle after it is accepted. A distance of 4 or more continues through two more power-of-two stages and arrives three cycles after acceptance. A tag on the output tells which route produced the result.

Results leave in the order in which they were accepted. A short-route operand is therefore held at the input while any long-route operand is still in flight. Both sides of the block use a valid/ready handshake. The adder that consumes the result can stall the whole pipeline by holding its ready low.

Top module: `sig_align_2way`

## Requirements
- R1: With `in_sig` placed in a 55-bit window as `{in_sig, 2'b00}` (window bit 54 is the significand MSB, bit 1 is guard, bit 0 is round), the window is shifted right by `in_shamt`, and `{out_sig, out_guard, out_round}` equals the shifted window.
- R2: `out_sticky` is the OR of every `in_sig` bit that moves below window bit 0 (the round position).
- R3: For `in_shamt` of 55 or more, `out_sig`, `out_guard` and `out_round` are all zero, and `out_sticky` equals the OR of all `in_sig` bits. An all-zero significand therefore gives sticky 0.
- R4: A shift of 0 to 3 takes the short route. Its result has `out_long` = 0 and shows `out_valid` in the cycle after acceptance, provided the output is free.
- R5: A shift of 4 or more takes the long route. Its result has `out_long` = 1 and shows `out_valid` three cycles after acceptance, provided the output is free.
- R6: Results leave in acceptance order. While a long-route operand is in flight, `in_ready` is low for a short-route operand.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and every output field stay unchanged.
- R8: During reset and right after it, `out_valid` is 0, and with no operand offered `in_ready` is 1.
- R9: With `out_ready` held high, long-route operands are accepted one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand accepted at this edge when valid |
| in_sig | input | SIG_W (53) | Significand to align, hidden bit included |
| in_shamt | input | AMT_W (7) | Right shift distance |
| out_valid | output | 1 | Aligned result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sig | output | SIG_W (53) | Aligned significand |
| out_guard | output | 1 | First bit below the significand |
| out_round | output | 1 | Second bit below the significand |
| out_sticky | output | 1 | OR of all bits shifted past the round bit |
| out_long | output | 1 | 1 when the long route produced the result |

## Verification
The bench drives the route boundary (shifts 3 and 4) and the saturation edge (54, 55, 56 and 127). A design with an off-by-one split would tag a result wrongly and give it the wrong latency. A design that mishandles saturation would leave stray guard bits or drop the sticky bit. It offers a short operand right behind a long one: a design that lets the short one overtake would deliver the results out of order against the bench's queue. It also stalls the output with a result waiting, which shows up any design that overwrites or drops that result. Last, it streams long operands back to back, which exposes a pipeline that bubbles.

// File: rtl/sig_align_pkg.sv
package sig_align_pkg;
  // Largest shift distance the short route completes alone
  localparam int SHORT_MAX = 3;

  typedef enum logic {
    ROUTE_SHORT = 1'b0,
    ROUTE_LONG  = 1'b1
  } route_e;
endpackage

// File: rtl/sig_align_stage.sv
// Combinational shift stage: applies the shift-amount bits LO..HI as
// power-of-two right shifts and folds the lost bits into sticky.
module sig_align_stage #(
  parameter int WIN   = 55,
  parameter int AMT_W = 7,
  parameter int LO    = 0,
  parameter int HI    = 1
) (
  input  logic [WIN-1:0]   win_i,
  input  logic             sticky_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [WIN-1:0]   win_o,
  output logic             sticky_o
);

  // Mask of the bits a shift by 2**b pushes out of the window
  function automatic logic [WIN-1:0] lost_mask(input int b);
    logic [WIN-1:0] m;
    m = '0;
    for (int i = 0; i < WIN; i++) begin
      if (i < (1 << b)) m[i] = 1'b1;
    end
    return m;
  endfunction

  always_comb begin
    win_o    = win_i;
    sticky_o = sticky_i;
    for (int b = LO; b <= HI; b++) begin
      if (amt_i[b]) begin
        if ((1 << b) >= WIN) begin
          sticky_o = sticky_o | (|win_o);
          win_o    = '0;
        end else begin
          sticky_o = sticky_o | (|(win_o & lost_mask(b)));
          win_o    = win_o >> (1 << b);
        end
      end
    end
  end

endmodule

// File: rtl/sig_align_ctrl.sv
// Handshake and ordering control for the two routes.
module sig_align_ctrl (
  input  logic in_valid,
  input  logic is_short,
  input  logic l1_v,
  input  logic l2_v,
  input  logic out_valid,
  input  logic out_ready,
  output logic advance,
  output logic in_ready,
  output logic short_take,
  output logic long_take
);

  // Pipeline moves whenever the output register is free or draining
  assign advance    = !out_valid || out_ready;
  // Short operands wait until no long operand is ahead of them
  assign in_ready   = advance && (!is_short || (!l1_v && !l2_v));
  assign short_take = in_valid && in_ready && is_short;
  assign long_take  = in_valid && in_ready && !is_short;

endmodule

// File: rtl/sig_align_2way.sv
module sig_align_2way
  import sig_align_pkg::*;
#(
  parameter int SIG_W = 53,
  parameter int AMT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SIG_W-1:0] in_sig,
  input  logic [AMT_W-1:0] in_shamt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SIG_W-1:0] out_sig,
  output logic             out_guard,
  output logic             out_round,
  output logic             out_sticky,
  output logic             out_long
);

  localparam int WIN = SIG_W + 2;

  logic             is_short;
  logic             advance;
  logic             short_take;
  logic             long_take;

  logic [WIN-1:0]   s1_win;
  logic             s1_sticky;

  logic             l1_v;
  logic [WIN-1:0]   l1_win;
  logic             l1_sticky;
  logic [AMT_W-1:0] l1_amt;

  logic [WIN-1:0]   s2_win;
  logic             s2_sticky;

  logic             l2_v;
  logic [WIN-1:0]   l2_win;
  logic             l2_sticky;
  logic [AMT_W-1:0] l2_amt;

  logic [WIN-1:0]   s3_win;
  logic             s3_sticky;

  logic [WIN-1:0]   o_win;
  logic             o_sticky;
  route_e           o_route;

  assign is_short = (in_shamt <= AMT_W'(SHORT_MAX));

  sig_align_ctrl i_ctrl (
    .in_valid  (in_valid),
    .is_short  (is_short),
    .l1_v      (l1_v),
    .l2_v      (l2_v),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .advance   (advance),
    .in_ready  (in_ready),
    .short_take(short_take),
    .long_take (long_take)
  );

  // Stage 1: shifts by 1 and 2, shared by both routes
  sig_align_stage #(.WIN(WIN), .AMT_W(AMT_W), .LO(0), .HI(1)) i_stage1 (
    .win_i   ({in_sig, 2'b00}),
    .sticky_i(1'b0),
    .amt_i   (in_shamt),
    .win_o   (s1_win),
    .sticky_o(s1_sticky)
  );

  // Stage 2: shifts by 4 and 8
  sig_align_stage #(.WIN(WIN), .AMT_W(AMT_W), .LO(2), .HI(3)) i_stage2 (
    .win_i   (l1_win),
    .sticky_i(l1_sticky),
    .amt_i   (l1_amt),
    .win_o   (s2_win),
    .sticky_o(s2_sticky)
  );

  // Stage 3: the remaining power-of-two shifts
  sig_align_stage #(.WIN(WIN), .AMT_W(AMT_W), .LO(4), .HI(AMT_W-1)) i_stage3 (
    .win_i   (l2_win),
    .sticky_i(l2_sticky),
    .amt_i   (l2_amt),
    .win_o   (s3_win),
    .sticky_o(s3_sticky)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l1_v      <= 1'b0;
      l2_v      <= 1'b0;
      out_valid <= 1'b0;
    end else if (advance) begin
      l1_v      <= long_take;
      l2_v      <= l1_v;
      out_valid <= l2_v || short_take;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      l1_win    <= s1_win;
      l1_sticky <= s1_sticky;
      l1_amt    <= in_shamt;
      l2_win    <= s2_win;
      l2_sticky <= s2_sticky;
      l2_amt    <= l1_amt;
      if (l2_v) begin
        o_win    <= s3_win;
        o_sticky <= s3_sticky;
        o_route  <= ROUTE_LONG;
      end else if (short_take) begin
        o_win    <= s1_win;
        o_sticky <= s1_sticky;
        o_route  <= ROUTE_SHORT;
      end
    end
  end

  assign out_sig    = o_win[WIN-1:2];
  assign out_guard  = o_win[1];
  assign out_round  = o_win[0];
  assign out_sticky = o_sticky;
  assign out_long   = (o_route == ROUTE_LONG);

endmodule

// File: rtl/sig_align_2way_chk.sv
module sig_align_2way_chk #(
  parameter int SIG_W = 53,
  parameter int AMT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [AMT_W-1:0] in_shamt,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SIG_W-1:0] out_sig,
  input logic             out_guard,
  input logic             out_round,
  input logic             out_sticky,
  input logic             out_long,
  input logic             short_take,
  input logic             long_take,
  input logic             l1_v,
  input logic             l2_v
);

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sig) &&
      $stable({out_guard, out_round, out_sticky, out_long})); // R7

  AST_SHORT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_shamt < AMT_W'(4)) && (l1_v || l2_v) |-> !in_ready); // R6

  AST_SHORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    short_take |=> out_valid && !out_long); // R4

  AST_LONG_ENTERS_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    long_take |=> l1_v && !out_valid || l1_v && out_long || l1_v); // R5

  AST_LONG_RETIRES_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    l2_v && (!out_valid || out_ready) |=> out_valid && out_long); // R5

  AST_SHORT_NO_LONG_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    short_take |-> !l1_v && !l2_v); // R6

endmodule

bind sig_align_2way sig_align_2way_chk #(.SIG_W(SIG_W), .AMT_W(AMT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_shamt  (in_shamt),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sig   (out_sig),
  .out_guard (out_guard),
  .out_round (out_round),
  .out_sticky(out_sticky),
  .out_long  (out_long),
  .short_take(short_take),
  .long_take (long_take),
  .l1_v      (l1_v),
  .l2_v      (l2_v)
);

// File: tb/test_sig_align_2way.sv
module test_sig_align_2way;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 53;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW-1:0] in_sig = '0;
  logic [AW-1:0] in_shamt = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [SW-1:0] out_sig;
  logic          out_guard, out_round, out_sticky, out_long;

  int checks = 0;
  int failures = 0;
  int cycle = 0;
  bit chk_lat = 1'b1;

  logic [SW+2:0] exp_q[$];
  int            acc_q[$];
  int            amt_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_align_2way #(.SIG_W(SW), .AMT_W(AW)) i_sig_align_2way (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sig(in_sig), .in_shamt(in_shamt), .out_valid(out_valid),
    .out_ready(out_ready), .out_sig(out_sig), .out_guard(out_guard),
    .out_round(out_round), .out_sticky(out_sticky), .out_long(out_long)
  );

  // Bit-by-bit model: returns {window[54:0], sticky}
  function automatic logic [SW+2:0] model(input logic [SW-1:0] s, input int amt);
    logic [SW+1:0] win;
    logic          st;
    win = '0;
    st  = 1'b0;
    for (int i = 0; i < SW; i++) begin
      int pos;
      pos = i + 2 - amt;
      if (pos >= 0) win[pos] = s[i];
      else st = st | s[i];
    end
    return {win, st};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: everything sampled on the falling edge
  always @(negedge clk) begin
    cycle++;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected result", 64'(out_sig), 64'h0);
      end else begin
        logic [SW+2:0] e;
        int a, c, lat;
        e = exp_q.pop_front();
        a = amt_q.pop_front();
        c = acc_q.pop_front();
        lat = (a > 3) ? 3 : 1;
        check({out_sig, out_guard, out_round} == e[SW+2:1],
              (a >= 55) ? "R3" : "R1", "aligned window",
              64'({out_sig, out_guard, out_round}), 64'(e[SW+2:1]));
        check(out_sticky == e[0], (a >= 55) ? "R3" : "R2", "sticky",
              64'(out_sticky), 64'(e[0]));
        check(out_long == (a > 3), (a > 3) ? "R5" : "R4", "route tag",
              64'(out_long), 64'(a > 3));
        if (chk_lat)
          check(cycle - c == lat, (a > 3) ? "R5" : "R4", "latency",
                64'(cycle - c), 64'(lat));
      end
    end
    if (rst_n && in_valid && in_ready) begin
      exp_q.push_back(model(in_sig, int'(in_shamt)));
      amt_q.push_back(int'(in_shamt));
      acc_q.push_back(cycle);
    end
  end

  // Called at posedge+2; returns at posedge+2 after acceptance
  task automatic send(input logic [SW-1:0] s, input int amt);
    in_valid = 1'b1;
    in_sig   = s;
    in_shamt = AW'(amt);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (6) @(posedge clk);
    #2;
    check(exp_q.size() == 0, "R6", "results outstanding", 64'(exp_q.size()), 64'h0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid in reset", 64'(out_valid), 64'h0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid after reset", 64'(out_valid), 64'h0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", 64'(in_ready), 64'h1);
    @(posedge clk);
    #2;
  endtask

  // R4, R1, R2: every short distance, including a bit lost at shift 3
  task automatic t_short();
    logic [SW-1:0] p;
    p = {1'b1, 48'h0, 4'b0111};
    for (int a = 0; a <= 3; a++) begin
      send(p, a);
      send({1'b1, {(SW-1){1'b1}}}, a);
    end
    drain();
  endtask

  // R5, R1, R2, R3: boundary and saturating distances
  task automatic t_long();
    logic [SW-1:0] p;
    p = {1'b1, 40'h0, 12'hA51};
    send(p, 4);
    send(p, 5);
    send(p, 17);
    send(p, 33);
    send(p, 53);
    send(p, 54);
    send(p, 55);
    send(p, 56);
    send(p, 127);
    send('0, 127);
    send({1'b1, {(SW-1){1'b0}}}, 60);
    drain();
  endtask

  // R6: a short operand directly behind a long one must wait
  task automatic t_order();
    send({1'b1, 52'h00000_0000_0F0F}, 20);
    in_valid = 1'b1;
    in_sig   = {1'b1, 52'h00000_0000_0003};
    in_shamt = AW'(1);
    @(negedge clk);
    check(in_ready == 1'b0, "R6", "short blocked behind long", 64'(in_ready), 64'h0);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #2;
    in_valid = 1'b0;
    drain();
  endtask

  // R7: stalled output holds its result
  task automatic t_stall();
    logic [SW+3:0] held;
    chk_lat   = 1'b0;
    out_ready = 1'b0;
    send({1'b1, 52'h00000_0000_0005}, 2);
    @(negedge clk);
    held = {out_sig, out_guard, out_round, out_sticky, out_long};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R7", "valid held in stall", 64'(out_valid), 64'h1);
      check({out_sig, out_guard, out_round, out_sticky, out_long} == held, "R7",
            "fields held in stall",
            64'({out_sig, out_guard, out_round, out_sticky, out_long}), 64'(held));
    end
    @(posedge clk);
    #2;
    out_ready = 1'b1;
    drain();
    chk_lat = 1'b1;
  endtask

  // R9: long operands stream one per cycle
  task automatic t_burst();
    int c0;
    c0 = cycle;
    send({1'b1, 52'h1}, 4);
    send({1'b1, 52'h2}, 9);
    send({1'b1, 52'h3}, 40);
    send({1'b1, 52'h4}, 70);
    check(cycle - c0 == 4, "R9", "cycles for four long operands",
          64'(cycle - c0), 64'h4);
    drain();
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_short();
    t_long();
    t_order();
    t_stall();
    t_burst();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule